// File: doc/BRIEF.md
# Three-wire SPI register access slave

This block lets an external host read and write a bank of configuration registers over a three-wire serial link. The link has a serial clock, an active-low chip select and one shared data line that carries both directions. Each frame opens when chip select falls. The host first sends a 16-bit instruction word, most significant bit first. The word holds a direction bit, a two-bit length code and a 13-bit start address. Data bytes follow the instruction.

For writes, the block collects each complete data byte. It hands the byte to the register bank as a one-cycle strobe with an address and data. For reads, it fetches each register over the same parallel port and turns the data line around to shift the contents back to the host. In both directions an internal counter steps the address from one byte to the next.

The serial clock, chip select and data input are resynchronised into the system clock domain, and all logic runs on that clock. The register port carries no ready signal because a serial host cannot be stalled. The bank must take every write strobe as it comes and return read data on the cycle after each read strobe.

Top module: `spi3w_reg_slave`

## Requirements
- R1: After reset, and while chip select is high, the data-line enable is low and neither the write strobe nor the read strobe is asserted.
- R2: The instruction is the first 16 bits of a frame, sent most significant bit first and sampled on rising serial clock edges. Bit 15 is the direction (1 = read, 0 = write). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R3: In a write frame, each completed data byte produces exactly one write strobe, one system cycle long, carrying the byte. The first byte goes to the start address, and each later byte goes to the previous address plus one.
- R4: Length codes 00, 01 and 10 allow one, two and three data bytes. In a write frame, bytes clocked beyond that count produce no strobe. In a read frame, bits clocked beyond that count read as 0.
- R5: With length code 11, bytes continue without limit, and the address keeps incrementing, until chip select rises.
- R6: In a read frame, the data line is not driven during the instruction. From the first falling serial clock edge after the instruction, the line is driven with the addressed register's contents, MSB first, with a new bit launched on each falling edge. It stays driven until chip select rises, after which it is released.
- R7: If chip select rises partway through a data byte, that byte produces no write strobe. Bytes completed earlier in the frame remain written.
- R8: The address counter is 13 bits wide, so it wraps from 0x1FFF to 0x0000.
- R9: In a read frame, one read strobe is issued before each counted data byte, with its address held for the following cycle. Read and write strobes are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk_i | input | 1 | Serial clock from the host |
| spi_csn_i | input | 1 | Active-low chip select from the host |
| spi_sdio_i | input | 1 | Data line as seen at the pad |
| spi_sdio_o | output | 1 | Data value driven onto the line during reads |
| spi_sdio_oe | output | 1 | Pad output enable for the data line |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 13 | Register address for the current strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rdata_i | input | 8 | Read data, valid the cycle after reg_rd_o |

## Verification
The checks assume that each level of the serial clock lasts at least six system clock cycles. They also assume that chip select changes only while the serial clock is low, and that the host changes the data line only while the serial clock is low. Under those conditions the synchroniser delay cannot make a byte-boundary strobe coincide with another edge, and a read fetch always completes before the next falling edge. The stimulus keeps each serial clock half period at ten system cycles. It drives all pins on falling system clock edges, holds chip select around the first and last serial edges by a full half period, and models the register bank as a one-cycle registered read.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;
endpackage

// File: rtl/spi3w_sync.sv
// Multi-stage synchroniser for asynchronous pad inputs.
module spi3w_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= RST_VAL;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi3w_frame.sv
// Frame sequencer: instruction capture, byte counting, address stepping
// and register port strobes.
module spi3w_frame
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              din_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              arm_o
);
  localparam int INS_W = 1 + LEN_W + ADDR_W;
  localparam int CNT_W = $clog2(INS_W);
  localparam int REM_W = LEN_W + 1;
  localparam logic [LEN_W-1:0] LEN_STREAM = '1;
  localparam logic [CNT_W-1:0] INS_LAST   = CNT_W'(INS_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(DATA_W - 1);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [INS_W-1:0]   sh_q;
  logic [ADDR_W-1:0]  cur_addr_q;
  logic [REM_W-1:0]   rem_q;
  logic               is_read_q;
  logic               stream_q;

  logic [INS_W-1:0]   word;
  logic               w_rw;
  logic [LEN_W-1:0]   w_len;
  logic [ADDR_W-1:0]  w_addr;
  logic [ADDR_W-1:0]  nxt_addr;
  logic               last_byte;

  always_comb begin
    word      = {sh_q[INS_W-2:0], din_i};
    w_rw      = word[INS_W-1];
    w_len     = word[INS_W-2 -: LEN_W];
    w_addr    = word[ADDR_W-1:0];
    nxt_addr  = cur_addr_q + ADDR_W'(1);
    last_byte = !stream_q && (rem_q == REM_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_INSTR;
      cnt_q      <= '0;
      sh_q       <= '0;
      cur_addr_q <= '0;
      rem_q      <= '0;
      is_read_q  <= 1'b0;
      stream_q   <= 1'b0;
      wr_o       <= 1'b0;
      rd_o       <= 1'b0;
      arm_o      <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
    end else begin
      wr_o  <= 1'b0;
      rd_o  <= 1'b0;
      arm_o <= 1'b0;
      if (!active_i) begin
        phase_q <= PH_INSTR;
        cnt_q   <= '0;
        sh_q    <= '0;
      end else if (rise_i) begin
        sh_q <= word;
        case (phase_q)
          PH_INSTR: begin
            if (cnt_q == INS_LAST) begin
              cnt_q      <= '0;
              phase_q    <= PH_DATA;
              is_read_q  <= w_rw;
              cur_addr_q <= w_addr;
              stream_q   <= (w_len == LEN_STREAM);
              rem_q      <= REM_W'(w_len) + REM_W'(1);
              if (w_rw) begin
                rd_o   <= 1'b1;
                arm_o  <= 1'b1;
                addr_o <= w_addr;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_DATA: begin
            if (cnt_q == BYTE_LAST) begin
              cnt_q      <= '0;
              cur_addr_q <= nxt_addr;
              if (!stream_q) rem_q <= rem_q - REM_W'(1);
              if (!is_read_q) begin
                wr_o    <= 1'b1;
                addr_o  <= cur_addr_q;
                wdata_o <= word[DATA_W-1:0];
              end
              if (last_byte) begin
                phase_q <= PH_DONE;
              end else if (is_read_q) begin
                rd_o   <= 1'b1;
                arm_o  <= 1'b1;
                addr_o <= nxt_addr;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: begin
            cnt_q <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/spi3w_tx.sv
// Read-side shifter: captures fetched register data and launches it
// on falling serial clock edges.
module spi3w_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              fall_i,
  input  logic              arm_i,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              sdio_o,
  output logic              sdio_oe_o
);
  logic              fetch_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pend_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      hold_q  <= '0;
      shreg_q <= '0;
      pend_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      fetch_q <= fetch_i;
      if (fetch_q) hold_q <= rdata_i;
      if (!active_i) begin
        pend_q  <= 1'b0;
        oe_q    <= 1'b0;
        shreg_q <= '0;
      end else begin
        if (arm_i) pend_q <= 1'b1;
        if (fall_i) begin
          if (pend_q) begin
            shreg_q <= hold_q;
            pend_q  <= 1'b0;
            oe_q    <= 1'b1;
          end else begin
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sdio_o    = shreg_q[DATA_W-1];
  assign sdio_oe_o = oe_q;
endmodule

// File: rtl/spi3w_reg_slave.sv
module spi3w_reg_slave #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk_i,
  input  logic              spi_csn_i,
  input  logic              spi_sdio_i,
  output logic              spi_sdio_o,
  output logic              spi_sdio_oe,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int PAD_W = 3;

  logic [PAD_W-1:0] pad_s;
  logic             csn_s;
  logic             sclk_s;
  logic             sdio_s;
  logic             sclk_d;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             frame_act;
  logic             load_arm;

  spi3w_sync #(
    .WIDTH   (PAD_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_csn_i, spi_sclk_i, spi_sdio_i}),
    .q_o   (pad_s)
  );

  assign {csn_s, sclk_s, sdio_s} = pad_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign frame_act = ~csn_s;

  spi3w_frame #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) i_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (frame_act),
    .rise_i   (sclk_rise),
    .din_i    (sdio_s),
    .wr_o     (reg_wr_o),
    .rd_o     (reg_rd_o),
    .addr_o   (reg_addr_o),
    .wdata_o  (reg_wdata_o),
    .arm_o    (load_arm)
  );

  spi3w_tx #(
    .DATA_W (DATA_W)
  ) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (frame_act),
    .fall_i    (sclk_fall),
    .arm_i     (load_arm),
    .fetch_i   (reg_rd_o),
    .rdata_i   (reg_rdata_i),
    .sdio_o    (spi_sdio_o),
    .sdio_oe_o (spi_sdio_oe)
  );
endmodule

// File: rtl/spi3w_chk.sv
module spi3w_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_act,
  input logic              sclk_rise,
  input logic              sdio_oe,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr
);
  // R1, R6: the line is released once the frame has closed
  a_r6_release_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> !sdio_oe);

  // R9: read and write strobes are mutually exclusive
  a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  // R3: each write strobe lasts one cycle
  a_r3_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R9: read address held for the cycle the bank answers
  a_r9_rd_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> $stable(reg_addr));

  // R6: no write is issued while the line is being driven
  a_r6_no_write_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !reg_wr);

  // R2: strobes follow a rising serial clock edge
  a_r2_strobe_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> $past(sclk_rise));
endmodule

bind spi3w_reg_slave spi3w_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_act (frame_act),
  .sclk_rise (sclk_rise),
  .sdio_oe   (spi_sdio_oe),
  .reg_wr    (reg_wr_o),
  .reg_rd    (reg_rd_o),
  .reg_addr  (reg_addr_o)
);

// File: tb/test_spi3w_reg_slave.sv
`timescale 1ns/1ps
module test_spi3w_reg_slave;
  localparam int CLK  = 10;
  localparam int HALF = 10 * CLK;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        csn = 1'b1;
  logic        sdio_h = 1'b0;
  logic        sdio_line;
  logic        sdio_o;
  logic        sdio_oe;
  logic        reg_wr;
  logic        reg_rd;
  logic [12:0] reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  bank_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0]  mem [256];
  logic [12:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  int          wcnt = 0;
  int          rcnt = 0;

  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  bit         oe_instr;
  bit         oe_gap;
  bit         oe_last;

  always #(CLK/2) clk = ~clk;

  assign sdio_line = sdio_oe ? sdio_o : sdio_h;

  spi3w_reg_slave i_spi3w_reg_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk_i  (sclk),
    .spi_csn_i   (csn),
    .spi_sdio_i  (sdio_line),
    .spi_sdio_o  (sdio_o),
    .spi_sdio_oe (sdio_oe),
    .reg_wr_o    (reg_wr),
    .reg_rd_o    (reg_rd),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (bank_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // Register bank model: registered read, logged writes
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      bank_rdata <= 8'h00;
    end else begin
      if (reg_rd) begin
        bank_rdata <= mem[reg_addr[7:0]];
        rcnt <= rcnt + 1;
      end
      if (reg_wr) begin
        mem[reg_addr[7:0]] <= reg_wdata;
        if (wcnt < 64) begin
          wlog_a[wcnt] <= reg_addr;
          wlog_d[wcnt] <= reg_wdata;
        end
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit rw, input logic [1:0] len, input logic [12:0] addr,
                      input int nbits);
    logic [15:0] ins;
    int          k;
    ins = {rw, len, addr};
    oe_instr = 0;
    oe_gap = 0;
    for (int i = 0; i < 8; i++) rxb[i] = 8'h00;
    @(negedge clk);
    csn = 1'b0;
    #HALF;
    for (int b = 0; b < 16 + nbits; b++) begin
      sclk = 1'b0;
      k = b - 16;
      if (b < 16) sdio_h = ins[15-b];
      else        sdio_h = txb[k/8][7-(k%8)];
      #HALF;
      if (b < 16) begin
        if (sdio_oe) oe_instr = 1;
      end else begin
        if (rw && !sdio_oe) oe_gap = 1;
        rxb[k/8][7-(k%8)] = sdio_o;
      end
      sclk = 1'b1;
      #HALF;
    end
    sclk = 1'b0;
    #HALF;
    oe_last = sdio_oe;
    csn = 1'b1;
    #(20 * CLK);
  endtask

  task automatic t_reset();
    chk(sdio_oe == 1'b0, "R1 oe after reset", sdio_oe, 0);
    chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R1 strobes after reset", {reg_wr, reg_rd}, 0);
  endtask

  task automatic t_write_single();
    int w0 = wcnt;
    txb[0] = 8'hA5;
    xfer(1'b0, 2'b00, 13'h0123, 8);
    chk(wcnt - w0 == 1, "R2 single write count", wcnt - w0, 1);
    chk(wlog_a[w0] == 13'h0123, "R2 single write addr", wlog_a[w0], 13'h0123);
    chk(wlog_d[w0] == 8'hA5, "R3 single write data", wlog_d[w0], 8'hA5);
    chk(sdio_oe == 1'b0, "R1 oe idle after write", sdio_oe, 0);
  endtask

  task automatic t_write_three();
    int w0 = wcnt;
    txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33;
    xfer(1'b0, 2'b10, 13'h0040, 24);
    chk(wcnt - w0 == 3, "R4 len10 write count", wcnt - w0, 3);
    for (int i = 0; i < 3; i++) begin
      chk(wlog_a[w0+i] == 13'h0040 + 13'(i), "R3 burst addr", wlog_a[w0+i], 13'h0040 + i);
      chk(wlog_d[w0+i] == txb[i], "R3 burst data", wlog_d[w0+i], txb[i]);
    end
  endtask

  task automatic t_write_extra();
    int w0 = wcnt;
    txb[0] = 8'h5A; txb[1] = 8'hC3;
    xfer(1'b0, 2'b00, 13'h00A0, 16);
    chk(wcnt - w0 == 1, "R4 extra byte ignored", wcnt - w0, 1);
    chk(mem[8'hA1] == init_val(8'hA1), "R4 next reg untouched", mem[8'hA1], init_val(8'hA1));
  endtask

  task automatic t_write_stream();
    int w0 = wcnt;
    for (int i = 0; i < 5; i++) txb[i] = 8'(8'h70 + i * 3);
    xfer(1'b0, 2'b11, 13'h00B0, 40);
    chk(wcnt - w0 == 5, "R5 stream write count", wcnt - w0, 5);
    chk(wlog_a[w0+4] == 13'h00B4, "R5 stream last addr", wlog_a[w0+4], 13'h00B4);
    chk(wlog_d[w0+4] == 8'h7C, "R5 stream last data", wlog_d[w0+4], 8'h7C);
    chk(rcnt == 0, "R9 no reads in write frames", rcnt, 0);
  endtask

  task automatic t_read_two();
    int w0 = wcnt;
    int r0 = rcnt;
    for (int i = 0; i < 8; i++) txb[i] = 8'hFF;
    xfer(1'b1, 2'b01, 13'h0040, 24);
    chk(oe_instr == 0, "R6 line free in instruction", oe_instr, 0);
    chk(oe_gap == 0, "R6 line driven in data", oe_gap, 0);
    chk(oe_last == 1, "R6 driven until cs rises", oe_last, 1);
    chk(sdio_oe == 0, "R6 released after cs", sdio_oe, 0);
    chk(rxb[0] == 8'h11, "R2 read byte0", rxb[0], 8'h11);
    chk(rxb[1] == 8'h22, "R3 read byte1 next addr", rxb[1], 8'h22);
    chk(rxb[2] == 8'h00, "R4 read beyond count zero", rxb[2], 8'h00);
    chk(rcnt - r0 == 2, "R9 read strobe count", rcnt - r0, 2);
    chk(wcnt == w0, "R9 no writes in read", wcnt - w0, 0);
  endtask

  task automatic t_read_stream();
    xfer(1'b1, 2'b11, 13'h00B0, 40);
    for (int i = 0; i < 5; i++)
      chk(rxb[i] == 8'(8'h70 + i * 3), "R5 stream read", rxb[i], 8'h70 + i * 3);
  endtask

  task automatic t_abort();
    int w0 = wcnt;
    logic [7:0] exp1;
    exp1 = mem[8'hC1];
    txb[0] = 8'h9E; txb[1] = 8'h42;
    xfer(1'b0, 2'b01, 13'h00C0, 12);
    chk(wcnt - w0 == 1, "R7 partial byte dropped", wcnt - w0, 1);
    chk(wlog_d[w0] == 8'h9E, "R7 full byte kept", wlog_d[w0], 8'h9E);
    xfer(1'b1, 2'b01, 13'h00C0, 16);
    chk(rxb[0] == 8'h9E, "R7 readback committed", rxb[0], 8'h9E);
    chk(rxb[1] == exp1, "R7 readback untouched", rxb[1], exp1);
  endtask

  task automatic t_wrap();
    int w0 = wcnt;
    txb[0] = 8'hE1; txb[1] = 8'hE2;
    xfer(1'b0, 2'b01, 13'h1FFF, 16);
    chk(wcnt - w0 == 2, "R8 wrap write count", wcnt - w0, 2);
    chk(wlog_a[w0] == 13'h1FFF, "R8 wrap first addr", wlog_a[w0], 13'h1FFF);
    chk(wlog_a[w0+1] == 13'h0000, "R8 wrap second addr", wlog_a[w0+1], 0);
  endtask

  initial begin
    #(200_000 * CLK);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_single();
    t_write_three();
    t_write_extra();
    t_write_stream();
    t_read_two();
    t_read_stream();
    t_abort();
    t_wrap();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule